// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog counter whose control bits can only be changed by a guarded write. The CPU side writes bytes over a simple address/data port. To open a short window, software first writes the key byte AAh and then the key byte 55h to the guard address C7h. The first write to any other address inside that window is a guarded write. It is the only kind of write that may restart the watchdog or change its enable and timeout-flag bits.

The guarded-write strobe is exported as a port, so other control registers elsewhere in the chip can use the same unlock. The counter advances on a clock-enable input. When it reaches its terminal count with the watchdog enabled, the block raises a one-cycle reset request and sets a sticky timeout flag. That flag is not cleared by the block's reset, so software can find the cause of the last reset.

Top module: `guarded_wdt`

## Requirements
- R1: While `rst_n` is low the counter is cleared, the window is closed, the enable bit is 0 and `wd_reset_req` is 0. After release, reading the power register gives the flag in bit 4, the enable in bit 2 and 0 in every other bit. The counter restarts from 0, so with the enable set the first request comes TIMEOUT enables after release.
- R2: Writing AAh and then 55h to address C7h opens the window. The next write to an address other than C7h drives `prot_wr` high in its own cycle.
- R3: The window does not open in three cases: 55h written without a preceding AAh, AAh followed by a byte other than 55h or AAh, or AAh followed by a write to another address. A repeated AAh rearms the search, so AAh, AAh, 55h does open the window.
- R4: The window closes after WIN_TICKS clock enables counted from the edge that took the 55h write. With WIN_TICKS=4, a write after 3 enables is guarded and a write after 4 is not. Cycles without a clock enable do not age the window.
- R5: A guarded write closes the window, so the write after it is not guarded. Any write to C7h while the window is open also closes it.
- R6: A guarded write of bit 7 = 1 to the control register clears the count, so the next request comes exactly TIMEOUT enables after that write's edge. The same write without the unlock is ignored. The control register reads back as 00h.
- R7: The counter advances once per clock enable. With the enable bit set, `wd_reset_req` is high for exactly one cycle, TIMEOUT enables after the last clear.
- R8: Bit 2 of the power register is the watchdog enable, and only a guarded write changes it. With the enable bit at 0, the count expires without a request and without setting the flag.
- R9: Bit 4 of the power register is set in the same cycle as the reset request. It survives `rst_n`, is ignored by unguarded writes, and is written by a guarded write to the power register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset: clears counter, unlock state and enable, but not the flag |
| tick_en | input | 1 | Clock enable for the counter and for window aging |
| wr_en | input | 1 | CPU write strobe |
| wr_addr | input | ADDR_W | CPU write address |
| wr_data | input | DATA_W | CPU write data |
| rd_addr | input | ADDR_W | CPU read address |
| rd_data | output | DATA_W | Read data, combinational from `rd_addr` |
| prot_wr | output | 1 | High during a write that falls inside the open window |
| wd_reset_req | output | 1 | One-cycle reset request at terminal count |

## Verification
The bench sweeps the number of enables between the 55h write and the candidate write from 0 to 6. A design that counted raw clocks, or that was off by one at the boundary, would accept the write after 4 enables or refuse it after 3. Broken and repeated key sequences are replayed to catch two faults: a design that opens on a lone 55h, and one that refuses AAh, AAh, 55h. The distance from a restart, or from reset release, to the request is measured in cycles; any counter that does not really clear, or that ignores the unlock, shifts that distance away from TIMEOUT. The flag is read across a reset pulse and after unguarded writes, which exposes a flag tied to reset or to plain writes.

// File: rtl/guarded_wdt_pkg.sv
package guarded_wdt_pkg;
   typedef enum logic [0:0] {
      SEEK_IDLE  = 1'b0,
      SEEK_ARMED = 1'b1
   } seek_state_t;
endpackage

// File: rtl/guarded_wdt_unlock.sv
module guarded_wdt_unlock
   import guarded_wdt_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'hC7,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
   parameter int WIN_TICKS   = 4,
   parameter bit WIN_CONSUME = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              win_open,
   output logic              prot_wr
);
   localparam int WW = $clog2(WIN_TICKS + 1);
   localparam logic [WW-1:0] WIN_LOAD = WW'(WIN_TICKS);

   seek_state_t    state_q;
   logic [WW-1:0]  win_q;
   logic [WW-1:0]  win_aged;
   logic [WW-1:0]  win_after_other;
   logic           guard_hit;

   assign guard_hit = wr_en && (wr_addr == GUARD_ADDR);
   assign win_open  = (win_q != '0);
   assign prot_wr   = wr_en && !guard_hit && win_open;
   assign win_aged  = (tick_en && win_open) ? win_q - 1'b1 : win_q;

   generate
      if (WIN_CONSUME) begin : g_single
         assign win_after_other = '0;
      end else begin : g_multi
         assign win_after_other = win_aged;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEEK_IDLE;
         win_q   <= '0;
      end else if (guard_hit) begin
         win_q <= '0;
         if (wr_data == KEY_FIRST) begin
            state_q <= SEEK_ARMED;
         end else if (state_q == SEEK_ARMED && wr_data == KEY_SECOND) begin
            state_q <= SEEK_IDLE;
            win_q   <= WIN_LOAD;
         end else begin
            state_q <= SEEK_IDLE;
         end
      end else if (wr_en) begin
         state_q <= SEEK_IDLE;
         win_q   <= win_after_other;
      end else begin
         win_q <= win_aged;
      end
   end
endmodule

// File: rtl/guarded_wdt_count.sv
module guarded_wdt_count #(
   parameter int TIMEOUT = 131072
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        tick_en,
   input  logic                        restart,
   input  logic                        enable,
   output logic [$clog2(TIMEOUT)-1:0]  count,
   output logic                        fire,
   output logic                        req
);
   localparam int CW = $clog2(TIMEOUT);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic at_last;

   assign at_last = tick_en && (count == LAST);
   assign fire    = at_last && enable && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
         req   <= 1'b0;
      end else begin
         req <= fire;
         if (restart || at_last) begin
            count <= '0;
         end else if (tick_en) begin
            count <= count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/guarded_wdt_regs.sv
module guarded_wdt_regs #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'hA9,
   parameter logic [ADDR_W-1:0] PWR_ADDR  = 8'h8E,
   parameter int RESTART_BIT = 7,
   parameter int FLAG_BIT    = 4,
   parameter int EN_BIT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              prot_wr,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              fire,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              restart,
   output logic              enable,
   output logic              flag,
   output logic [DATA_W-1:0] rd_data
);
   logic pwr_hit;
   logic flag_q = 1'b0;

   assign pwr_hit = prot_wr && (wr_addr == PWR_ADDR);
   assign restart = prot_wr && (wr_addr == CTRL_ADDR) && wr_data[RESTART_BIT];
   assign flag    = flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable <= 1'b0;
      end else if (pwr_hit) begin
         enable <= wr_data[EN_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (fire) begin
         flag_q <= 1'b1;
      end else if (pwr_hit) begin
         flag_q <= wr_data[FLAG_BIT];
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == PWR_ADDR) begin
         rd_data[FLAG_BIT] = flag_q;
         rd_data[EN_BIT]   = enable;
      end
   end
endmodule

// File: rtl/guarded_wdt.sv
module guarded_wdt #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'hC7,
   parameter logic [ADDR_W-1:0] CTRL_ADDR  = 8'hA9,
   parameter logic [ADDR_W-1:0] PWR_ADDR   = 8'h8E,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'hAA,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
   parameter int WIN_TICKS   = 4,
   parameter bit WIN_CONSUME = 1'b1,
   parameter int TIMEOUT     = 131072,
   parameter int RESTART_BIT = 7,
   parameter int FLAG_BIT    = 4,
   parameter int EN_BIT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              prot_wr,
   output logic              wd_reset_req
);
   localparam int CW = $clog2(TIMEOUT);

   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("TIMEOUT must be at least 2");
      end
      if (WIN_TICKS < 1) begin : g_bad_window
         $error("WIN_TICKS must be at least 1");
      end
      if (RESTART_BIT >= DATA_W || FLAG_BIT >= DATA_W || EN_BIT >= DATA_W) begin : g_bad_bits
         $error("bit positions must fit in DATA_W");
      end
      if (FLAG_BIT == EN_BIT) begin : g_bad_overlap
         $error("flag and enable bits must differ");
      end
      if (GUARD_ADDR == CTRL_ADDR || GUARD_ADDR == PWR_ADDR || CTRL_ADDR == PWR_ADDR) begin : g_bad_addr
         $error("register addresses must be distinct");
      end
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_keys
         $error("key bytes must differ");
      end
   endgenerate

   logic          win_open;
   logic          restart;
   logic          enable;
   logic          flag;
   logic          fire;
   logic [CW-1:0] count;

   guarded_wdt_unlock #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_ADDR(GUARD_ADDR),
      .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND),
      .WIN_TICKS(WIN_TICKS), .WIN_CONSUME(WIN_CONSUME)
   ) unlock_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .win_open(win_open), .prot_wr(prot_wr)
   );

   guarded_wdt_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR), .PWR_ADDR(PWR_ADDR),
      .RESTART_BIT(RESTART_BIT), .FLAG_BIT(FLAG_BIT), .EN_BIT(EN_BIT)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .prot_wr(prot_wr), .wr_addr(wr_addr), .wr_data(wr_data),
      .fire(fire), .rd_addr(rd_addr), .restart(restart), .enable(enable),
      .flag(flag), .rd_data(rd_data)
   );

   guarded_wdt_count #(
      .TIMEOUT(TIMEOUT)
   ) count_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .restart(restart),
      .enable(enable), .count(count), .fire(fire), .req(wd_reset_req)
   );
endmodule

// File: rtl/guarded_wdt_chk.sv
module guarded_wdt_chk #(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 8,
   parameter logic [ADDR_W-1:0] GUARD_ADDR = 8'hC7,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
   parameter bit WIN_CONSUME = 1'b1,
   parameter int CW          = 17
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              prot_wr,
   input logic              win_open,
   input logic              restart,
   input logic              enable,
   input logic              flag,
   input logic [CW-1:0]     count,
   input logic              wd_reset_req
);
   // R7
   req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_req |=> !wd_reset_req);

   // R9
   req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wd_reset_req |-> flag);

   // R2
   window_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_open) |-> $past(wr_en && wr_addr == GUARD_ADDR && wr_data == KEY_SECOND));

   // R5
   window_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_wr && WIN_CONSUME) |=> !win_open);

   // R6
   restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (count == '0));

   // R8
   enable_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prot_wr |=> $stable(enable));
endmodule

bind guarded_wdt guarded_wdt_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .GUARD_ADDR(GUARD_ADDR),
   .KEY_SECOND(KEY_SECOND), .WIN_CONSUME(WIN_CONSUME), .CW(CW)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .prot_wr(prot_wr), .win_open(win_open), .restart(restart), .enable(enable),
   .flag(flag), .count(count), .wd_reset_req(wd_reset_req)
);

// File: tb/guarded_wdt_tb.sv
`timescale 1ns/1ps
module guarded_wdt_tb_top;
   localparam int TO   = 16;
   localparam int WIN  = 4;
   localparam logic [7:0] GA = 8'hC7;
   localparam logic [7:0] CA = 8'hA9;
   localparam logic [7:0] PA = 8'h8E;
   localparam logic [7:0] OA = 8'h30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       prot_wr;
   logic       wd_reset_req;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int req_cnt = 0;
   logic last_prot;
   bit finished = 1'b0;

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) if (wd_reset_req) req_cnt <= req_cnt + 1;

   guarded_wdt #(.WIN_TICKS(WIN), .TIMEOUT(TO)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .prot_wr(prot_wr), .wd_reset_req(wd_reset_req)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      #1 last_prot = prot_wr;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic unlock();
      wr(GA, 8'hAA);
      wr(GA, 8'h55);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic read_pwr(output int v);
      rd_addr = PA;
      #1 v = rd_data;
   endtask

   task automatic wait_req(output int at);
      at = -1;
      for (int i = 0; i < 100; i++) begin
         if (wd_reset_req) begin
            at = cyc;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #2000000;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int v, c0, at;
      @(negedge clk);
      idle(2);
      // R1 reset state
      check("R1 req in reset", wd_reset_req, 0);
      rst_n = 1'b1;
      read_pwr(v);
      check("R1 power reg after reset", v, 0);
      rd_addr = CA;
      #1 check("R1 control reg reads zero", rd_data, 0);
      @(negedge clk);

      // R8 disabled: no request over a long run
      req_cnt = 0;
      idle(3 * TO);
      check("R8 no request while disabled", req_cnt, 0);
      read_pwr(v);
      check("R8 flag stays clear while disabled", v, 0);

      // R4 window sweep over enables after the second key
      for (int k = 0; k <= 6; k++) begin
         unlock();
         idle(k);
         wr(OA, 8'h00);
         check($sformatf("R4 window after %0d enables", k), last_prot, (k < WIN) ? 1 : 0);
      end
      tick_en = 1'b0;
      unlock();
      idle(9);
      wr(OA, 8'h00);
      check("R4 window does not age without enables", last_prot, 1);
      tick_en = 1'b1;

      // R2 basic unlock
      unlock();
      wr(OA, 8'h11);
      check("R2 write after keys is guarded", last_prot, 1);
      // R5 single use
      wr(OA, 8'h22);
      check("R5 second write not guarded", last_prot, 0);
      unlock();
      wr(GA, 8'h12);
      wr(OA, 8'h00);
      check("R5 guard-address write closes window", last_prot, 0);

      // R3 broken sequences
      wr(GA, 8'h55);
      wr(OA, 8'h00);
      check("R3 lone second key", last_prot, 0);
      wr(GA, 8'hAA);
      wr(GA, 8'h33);
      wr(OA, 8'h00);
      check("R3 wrong second byte", last_prot, 0);
      wr(GA, 8'hAA);
      wr(OA, 8'h00);
      check("R3 interleaved write not guarded", last_prot, 0);
      wr(GA, 8'h55);
      wr(OA, 8'h00);
      check("R3 interleaved write breaks sequence", last_prot, 0);
      wr(GA, 8'hAA);
      wr(GA, 8'hAA);
      wr(GA, 8'h55);
      wr(OA, 8'h00);
      check("R3 repeated first key rearms", last_prot, 1);

      // R8 unguarded enable ignored
      wr(PA, 8'h04);
      read_pwr(v);
      check("R8 unguarded enable ignored", v, 0);
      unlock();
      wr(PA, 8'h04);
      read_pwr(v);
      check("R8 guarded enable sets bit 2", v, 8'h04);

      // R6/R7 restart then timeout distance
      unlock();
      wr(CA, 8'h80);
      c0 = cyc;
      rd_addr = CA;
      #1 check("R6 control reg reads zero after restart", rd_data, 0);
      wait_req(at);
      check("R7 request TIMEOUT enables after restart", at - c0, TO);
      @(negedge clk);
      check("R7 request lasts one cycle", wd_reset_req, 0);
      read_pwr(v);
      check("R9 flag set by timeout", v, 8'h14);

      // R6 unguarded restart ignored
      unlock();
      wr(CA, 8'h80);
      c0 = cyc;
      idle(5);
      wr(CA, 8'h80);
      wait_req(at);
      check("R6 unguarded restart ignored", at - c0, TO);

      // R6 guarded restart mid-count
      unlock();
      wr(CA, 8'h80);
      idle(7);
      unlock();
      wr(CA, 8'h80);
      c0 = cyc;
      wait_req(at);
      check("R6 mid-count restart clears count", at - c0, TO);

      // R9 unguarded write cannot clear flag
      wr(PA, 8'h00);
      read_pwr(v);
      check("R9 unguarded write keeps flag", v, 8'h14);

      // R9/R1 flag survives reset, enable cleared
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      c0 = cyc;
      read_pwr(v);
      check("R9 flag survives reset", v, 8'h10);
      unlock();
      wr(PA, 8'h04);
      wait_req(at);
      check("R1 counter restarts from zero at reset", at - c0, TO);
      read_pwr(v);
      check("R9 flag set again", v, 8'h14);

      // R9 guarded clear, R8 disable
      unlock();
      wr(PA, 8'h00);
      read_pwr(v);
      check("R9 guarded write clears flag and enable", v, 0);
      req_cnt = 0;
      idle(3 * TO);
      check("R8 disabled after guarded clear", req_cnt, 0);
      read_pwr(v);
      check("R8 flag not set while disabled", v, 0);

      finish_run();
   end
endmodule